// File: doc/BRIEF.md
# Ingress Forwarding-Point Controller

This block watches the byte stream of one ingress Ethernet port and decides the earliest moment at which the egress side may begin sending the frame. Three run-time policies are offered. In the low-latency policy, release comes as soon as the destination MAC address has arrived. In the collision-safe policy, release waits until the minimum legal frame size has arrived. In the fully checked policy, release waits for the whole frame and its FCS verdict. The block also captures the destination address and classifies every frame at its end. It signals the end of each frame with either a commit or a discard, and it keeps a saturating counter for each kind of error.

The stream is a tap on an existing valid/ready link. A byte is taken only in a cycle where both `in_valid` and `in_ready` are high. The block never applies back-pressure of its own: a stalled beat (`in_valid` high, `in_ready` low) carries no meaning and is ignored in full. `in_last` and `in_fcs_err` are looked at only on an accepted beat. `in_fcs_err` comes from an external CRC checker and has meaning only on the final beat. Every strobe is registered and appears in the cycle after the edge that accepted the byte which caused it.

Top module: `fwd_mode_ctrl`

## Requirements
- R1: A byte counts only on a cycle with in_valid and in_ready both high. Beats stalled by in_ready low, whatever their data, last or FCS values, change no output and no count.
- R2: mode_sel is sampled on the first accepted byte of a frame (code 0 low-latency, 1 collision-safe, 2 or 3 fully checked). Changing it later in the frame has no effect until the next frame.
- R3: In low-latency mode, fwd_start pulses for one cycle, one cycle after byte number CT_BYTES (default 6) is accepted. A frame that ends before that byte gets no fwd_start.
- R4: In collision-safe mode, fwd_start pulses one cycle after byte number MIN_LEN (default 64) is accepted. A frame that ends before that byte gets no fwd_start and is discarded.
- R5: In fully checked mode, fwd_start pulses only together with fwd_commit, at the end of an error-free frame. An erroneous frame gets no fwd_start.
- R6: Each frame gets at most one cause, fixed on its last byte from its length L (bytes including FCS) and the FCS flag. L > MAX_LEN (1518) is a giant, whatever the FCS. L < MIN_LEN with a bad FCS is a fragment. L < MIN_LEN with a good FCS is a runt. A length in range with a bad FCS is a CRC error.
- R7: Every frame ends with exactly one one-cycle strobe, one cycle after its last byte: fwd_commit if it has no cause, otherwise fwd_discard.
- R8: Each error counter (runt, fragment, CRC, giant) adds one for each frame of its cause. It stops at all-ones of its CNT_W width (default 16) and never wraps.
- R9: dst_addr holds the first six bytes of the current or most recent frame. The first byte is in bits 47:40 and the sixth is in bits 7:0.
- R10: After reset all strobes, dst_addr and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | input | 1 | Stream byte ready from the sink |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of frame |
| in_fcs_err | input | 1 | FCS failed, meaningful on the final byte |
| mode_sel | input | 2 | Forwarding policy select |
| fwd_start | output | 1 | Egress may start sending |
| fwd_commit | output | 1 | Frame ended clean |
| fwd_discard | output | 1 | Frame ended with an error |
| dst_addr | output | 48 | Captured destination address |
| cnt_runt | output | CNT_W | Runt frame count |
| cnt_frag | output | CNT_W | Fragment count |
| cnt_crc | output | CNT_W | CRC-error count |
| cnt_giant | output | CNT_W | Giant frame count |

## Verification
The assertions assume that reset is held for at least one clock edge before the first frame. They also assume that in_fcs_err is valid on every accepted final beat, and that frames are never interleaved, so each frame ends with in_last before the next one begins. The stimulus drives whole frames one after another and drops in_valid between them. It inserts stall beats carrying a fake last and a bad FCS only while in_ready is low. It switches mode_sel mid-frame only to show that the change is ignored. The testbench shrinks CNT_W so that saturation can be reached in a short run.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef enum logic [1:0] {
    FM_CUT   = 2'd0,
    FM_FRAG  = 2'd1,
    FM_STORE = 2'd2
  } fwd_mode_e;

  typedef struct packed {
    logic giant;
    logic crc;
    logic frag;
    logic runt;
  } cause_t;

  localparam int NUM_CAUSE = 4;

  function automatic fwd_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'd0:    return FM_CUT;
      2'd1:    return FM_FRAG;
      default: return FM_STORE;
    endcase
  endfunction

endpackage

// File: rtl/fmc_len_track.sv
module fmc_len_track #(
  parameter int MAX_LEN    = 1518,
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc,
  input  logic                    last,
  input  logic [7:0]              data,
  output logic [LEN_W-1:0]        len_now,
  output logic                    first,
  output logic [8*ADDR_BYTES-1:0] addr_q
);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN + 1);

  logic [LEN_W-1:0] cnt_q;

  assign first   = (cnt_q == '0);
  assign len_now = (cnt_q == LEN_SAT) ? LEN_SAT : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (acc) cnt_q <= last ? '0 : len_now;
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        addr_q[8*(ADDR_BYTES-1-g) +: 8] <= '0;
      else if (acc && cnt_q == LEN_W'(g))
        addr_q[8*(ADDR_BYTES-1-g) +: 8] <= data;
    end
  end

  // R6: byte count never passes the giant saturation point
  assert_len_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_SAT);

  // R1: count only moves on an accepted byte
  assert_cnt_needs_acc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(cnt_q));

endmodule

// File: rtl/fmc_classify.sv
module fmc_classify
  import fmc_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = 11
) (
  input  logic [LEN_W-1:0] len,
  input  logic             fcs_bad,
  output cause_t           cause
);
  logic short_len, long_len;

  assign short_len = (len < LEN_W'(MIN_LEN));
  assign long_len  = (len > LEN_W'(MAX_LEN));

  always_comb begin
    cause       = '0;
    cause.giant = long_len;
    cause.frag  = short_len &&  fcs_bad;
    cause.runt  = short_len && !fcs_bad;
    cause.crc   = !short_len && !long_len && fcs_bad;
  end

  // R6: one cause at most
  always_comb begin
    if (!$isunknown(cause))
      assert_one_cause_R6: assert ($onehot0(cause));
  end

endmodule

// File: rtl/fmc_sat_cnt.sv
module fmc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == TOP |=> cnt == TOP);

  assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/fwd_mode_ctrl.sv
module fwd_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1518,
  parameter int CT_BYTES = 6,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_fcs_err,
  input  logic [1:0]       mode_sel,
  output logic             fwd_start,
  output logic             fwd_commit,
  output logic             fwd_discard,
  output logic [47:0]      dst_addr,
  output logic [CNT_W-1:0] cnt_runt,
  output logic [CNT_W-1:0] cnt_frag,
  output logic [CNT_W-1:0] cnt_crc,
  output logic [CNT_W-1:0] cnt_giant
);
  localparam int ADDR_BYTES = 6;
  localparam int LEN_W      = $clog2(MAX_LEN + 2);

  logic             acc, first;
  logic [LEN_W-1:0] len_now;
  fwd_mode_e        mode_q, eff_mode;
  cause_t           cause;
  logic             bad_end, early_hit, start_d, commit_d, discard_d;
  logic [NUM_CAUSE-1:0]  inc_vec;
  logic [CNT_W-1:0]      cnt_arr [NUM_CAUSE];

  assign acc = in_valid && in_ready;

  fmc_len_track #(.MAX_LEN(MAX_LEN), .ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .acc(acc), .last(in_last), .data(in_data),
    .len_now(len_now), .first(first), .addr_q(dst_addr)
  );

  fmc_classify #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cls (
    .len(len_now), .fcs_bad(in_fcs_err), .cause(cause)
  );

  // mode latched on the first byte of each frame
  assign eff_mode = first ? decode_mode(mode_sel) : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_q <= FM_STORE;
    else if (acc && first) mode_q <= eff_mode;
  end

  always_comb begin
    bad_end   = in_last && (cause != '0);
    early_hit = 1'b0;
    case (eff_mode)
      FM_CUT:  early_hit = (len_now == LEN_W'(CT_BYTES));
      FM_FRAG: early_hit = (len_now == LEN_W'(MIN_LEN));
      default: early_hit = 1'b0;
    endcase
    start_d   = acc && (early_hit ||
                        (eff_mode == FM_STORE && in_last && !bad_end));
    commit_d  = acc && in_last && !bad_end;
    discard_d = acc && bad_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_start   <= 1'b0;
      fwd_commit  <= 1'b0;
      fwd_discard <= 1'b0;
    end else begin
      fwd_start   <= start_d;
      fwd_commit  <= commit_d;
      fwd_discard <= discard_d;
    end
  end

  assign inc_vec = (acc && in_last) ? cause : '0;

  for (genvar c = 0; c < NUM_CAUSE; c++) begin : g_cnt
    fmc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[c]), .cnt(cnt_arr[c])
    );
  end

  assign cnt_runt  = cnt_arr[0];
  assign cnt_frag  = cnt_arr[1];
  assign cnt_crc   = cnt_arr[2];
  assign cnt_giant = cnt_arr[3];

  // R7: a frame never ends both ways
  assert_end_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_commit && fwd_discard));

  // R1: strobes only follow an accepted byte
  assert_strobe_after_acc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_start || fwd_commit || fwd_discard) |-> $past(acc));

  // R5: in fully checked mode the release coincides with commit
  assert_store_start_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_start && mode_q == FM_STORE) |-> fwd_commit);

  // R3/R4: early release never repeats on the next cycle
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_start && mode_q != FM_STORE) |=> !fwd_start);

endmodule

// File: tb/test_fwd_mode_ctrl.sv
module test_fwd_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int NV = 10;
  localparam int MINL = 64;
  localparam int MAXL = 1518;

  // len, mode, fcs bad, stall beats
  localparam int T_LEN  [NV] = '{100, 4, 80, 63, 64, 64, 40, 1519, 1518, 70};
  localparam int T_MODE [NV] = '{0,   0, 1,  1,  1,  2,  2,  2,    0,    3 };
  localparam int T_FCS  [NV] = '{0,   0, 1,  0,  0,  0,  1,  0,    0,    1 };
  localparam int T_GAP  [NV] = '{0,   0, 0,  1,  0,  1,  0,  0,    1,    0 };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready = 0, in_last = 0, in_fcs_err = 0;
  logic [7:0] in_data = 0;
  logic [1:0] mode_sel = 0;
  logic fwd_start, fwd_commit, fwd_discard;
  logic [47:0] dst_addr;
  logic [CW-1:0] cnt_runt, cnt_frag, cnt_crc, cnt_giant;

  int checks = 0, errors = 0;
  int e_runt = 0, e_frag = 0, e_crc = 0, e_giant = 0;
  int n_start, start_at, n_commit, n_disc;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_mode_ctrl #(.CNT_W(CW)) i_fwd_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_fcs_err(in_fcs_err),
    .mode_sel(mode_sel), .fwd_start(fwd_start), .fwd_commit(fwd_commit),
    .fwd_discard(fwd_discard), .dst_addr(dst_addr), .cnt_runt(cnt_runt),
    .cnt_frag(cnt_frag), .cnt_crc(cnt_crc), .cnt_giant(cnt_giant)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sample(input int idx);
    if (fwd_start) begin n_start++; start_at = idx; end
    if (fwd_commit)  n_commit++;
    if (fwd_discard) n_disc++;
  endtask

  function automatic int satc(input int v);
    return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
  endfunction

  task automatic send_frame(input int len, input int mode, input int mode2,
                            input bit fcs, input bit gap, input bit full_chk);
    int m, exp_at;
    bit err;
    n_start = 0; start_at = 0; n_commit = 0; n_disc = 0;
    for (int k = 1; k <= len; k++) begin
      if (gap && (k % 2 == 0)) begin
        // stalled beat with misleading contents (R1)
        in_valid = 1; in_ready = 0; in_data = 8'hEE; in_last = 1; in_fcs_err = 1;
        mode_sel = 2'(mode2);
        @(negedge clk); sample(k - 1);
      end
      in_valid = 1; in_ready = 1; in_data = 8'(k + 8'h20);
      in_last = (k == len); in_fcs_err = (k == len) ? fcs : 1'b0;
      mode_sel = (k == 1) ? 2'(mode) : 2'(mode2);
      @(negedge clk); sample(k);
    end
    in_valid = 0; in_last = 0; in_fcs_err = 0;
    @(negedge clk); sample(len + 1);

    m   = (mode == 3) ? 2 : mode;
    err = (len < MINL) || (len > MAXL) || fcs;
    if (len > MAXL)            e_giant++;
    else if (len < MINL && fcs)  e_frag++;
    else if (len < MINL)         e_runt++;
    else if (fcs)                e_crc++;
    if (m == 0)      exp_at = (len >= 6) ? 6 : 0;
    else if (m == 1) exp_at = (len >= MINL) ? MINL : 0;
    else             exp_at = err ? 0 : len;
    if (!full_chk) return;
    // R3 R4 R5: release point; R2 mode latched
    check(m == 0 ? "R3" : (m == 1 ? "R4" : "R5"), "start count", n_start, exp_at != 0);
    check(m == 0 ? "R3" : (m == 1 ? "R4" : "R5"), "start byte",  start_at, exp_at);
    check("R7", "commit count",  n_commit, !err);
    check("R7", "discard count", n_disc, err);
    check("R8", "runt count",  cnt_runt,  satc(e_runt));
    check("R6", "frag count",  cnt_frag,  satc(e_frag));
    check("R6", "crc count",   cnt_crc,   satc(e_crc));
    check("R6", "giant count", cnt_giant, satc(e_giant));
    if (len >= 6) check("R9", "dst addr", dst_addr, 48'h212223242526);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "start",   fwd_start, 0);
    check("R10", "commit",  fwd_commit, 0);
    check("R10", "discard", fwd_discard, 0);
    check("R10", "dst",     dst_addr, 0);
    check("R10", "counters", {cnt_runt, cnt_frag, cnt_crc, cnt_giant}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      send_frame(T_LEN[i], T_MODE[i], T_MODE[i], T_FCS[i][0], T_GAP[i][0], 1);

    // R2: mode change mid-frame ignored, then honoured on next frame
    send_frame(100, 0, 2, 0, 0, 1);
    send_frame(100, 2, 0, 0, 1, 1);
    // R4: collision-safe frame with bad FCS below 64 is a fragment, no start
    send_frame(30, 1, 1, 1, 0, 1);

    // R8: drive the runt counter into saturation
    for (int j = 0; j < 16; j++) send_frame(2, 2, 2, 0, 0, 0);
    check("R8", "runt saturated", cnt_runt, (1 << CW) - 1);
    send_frame(2, 2, 2, 0, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule